// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer with Match Event

This block is a memory-mapped general-purpose timer. Software uses it as a free-running microsecond time base. A prescaler divides the input clock so that a 32-bit counter steps down once per chosen period. When the counter is at zero on a step, it reloads from a programmable interval value and flags a timeout. When a step leaves the counter equal to a programmable compare value, it flags a match. Software reads the live count at any time. Because the counter runs downward, software complements the count against all ones to obtain an increasing time. It programs the compare value in the same complemented way to schedule the next deadline.

Both events latch in a raw status register whether or not they are masked. The interrupt line is the OR of every raw event whose mask bit is set. Software acknowledges events by writing ones to a clear register, and writing back the raw status value acknowledges everything pending. The register port is a plain select/write-enable bus with a combinational read path.

Top module: `pdtimer`

## Requirements
- R1: After reset every writable register reads 0, the raw status reads 0, the count reads 0 and `irq` is 0.
- R2: The counter moves only while the run condition holds. The run condition is control bit 0 set, the configuration register equal to 4, and mode bits [1:0] equal to 2'b10. Otherwise the count holds, and clearing control bit 0 stops it.
- R3: On the first clock in which the run condition holds, the counter loads the interval register and the prescaler restarts from the prescale register. The first step follows P+1 clocks later, where P is the prescale value.
- R4: While running, the counter steps once every P+1 clocks. A step from a non-zero count decrements it by one.
- R5: A step taken at count 0 reloads the interval register instead of decrementing, and sets raw status bit 0 (timeout). An interval of 0xFFFFFFFF is accepted and the first step then gives 0xFFFFFFFE.
- R6: A step (or reload) whose new count equals the compare register sets raw status bit 4 (match).
- R7: Raw bits 0 and 4 set regardless of the mask and stay set until cleared. `irq` is high exactly when some raw bit is set together with the same bit of the mask register.
- R8: A write to the clear register clears each raw bit written as 1 and leaves bits written as 0 unchanged. If an event and its clear land in the same clock, the bit stays set.
- R9: Word addresses are 0 control (bits 0 and 8 kept), 1 configuration (bits [2:0] kept), 2 mode (bits [7:0] kept), 3 interval, 4 compare, 5 prescale (bits [15:0] kept), 6 mask (bits 0 and 4 kept), 7 raw status (read only), 8 clear (write only, reads 0), 9 live count (read only). Unkept bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
A timeout event and a software clear of the same raw bit can fall in one clock. The bench provokes this with an interval of 0 and a prescale of 0. The counter then reloads to zero on every clock and raises a timeout each cycle, so any clear of bit 0 is certain to meet an event. The raw status is read back in the low phase right after the clearing edge. It must still show bit 0 set, while the match bit cleared in the same write must read 0.

// File: rtl/pdtimer_pkg.sv
package pdtimer_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int CFG_W  = 3;
  localparam int MODE_W = 8;
  localparam int NEV    = 2;
  localparam int EV_TO  = 0;
  localparam int EV_MT  = 1;
  localparam int EV_BITPOS [NEV] = '{0, 4};

  localparam logic [CFG_W-1:0] CFG_WIDE = 3'd4;
  localparam logic [1:0]       MODE_PER = 2'b10;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LOAD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MATCH = 4'd4;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd9;
endpackage

// File: rtl/pdtimer_regs.sv
module pdtimer_regs
  import pdtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [NEV-1:0]    raw,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              run,
  output logic [CNT_W-1:0]  load,
  output logic [CNT_W-1:0]  match,
  output logic [PRE_W-1:0]  presc,
  output logic [NEV-1:0]    mask,
  output logic              clr_wr,
  output logic [NEV-1:0]    clr_bits
);
  logic              en_a_q, en_b_q, en_a_d, en_b_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  load_q, load_d, match_q, match_d;
  logic [PRE_W-1:0]  presc_q, presc_d;
  logic [NEV-1:0]    mask_q, mask_d, wbits;
  logic              wr;

  assign wr = bus_sel & bus_we;

  always_comb begin
    for (int g = 0; g < NEV; g++) wbits[g] = bus_wdata[EV_BITPOS[g]];
  end

  always_comb begin
    en_a_d  = en_a_q;
    en_b_d  = en_b_q;
    cfg_d   = cfg_q;
    mode_d  = mode_q;
    load_d  = load_q;
    match_d = match_q;
    presc_d = presc_q;
    mask_d  = mask_q;
    if (wr) begin
      case (bus_addr)
        A_CTRL:  begin en_a_d = bus_wdata[0]; en_b_d = bus_wdata[8]; end
        A_CFG:   cfg_d   = bus_wdata[CFG_W-1:0];
        A_MODE:  mode_d  = bus_wdata[MODE_W-1:0];
        A_LOAD:  load_d  = bus_wdata[CNT_W-1:0];
        A_MATCH: match_d = bus_wdata[CNT_W-1:0];
        A_PRESC: presc_d = bus_wdata[PRE_W-1:0];
        A_MASK:  mask_d  = wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      cfg_q   <= '0;
      mode_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      presc_q <= '0;
      mask_q  <= '0;
    end else begin
      en_a_q  <= en_a_d;
      en_b_q  <= en_b_d;
      cfg_q   <= cfg_d;
      mode_q  <= mode_d;
      load_q  <= load_d;
      match_q <= match_d;
      presc_q <= presc_d;
      mask_q  <= mask_d;
    end
  end

  assign run      = en_a_q && (cfg_q == CFG_WIDE) && (mode_q[1:0] == MODE_PER);
  assign load     = load_q;
  assign match    = match_q;
  assign presc    = presc_q;
  assign mask     = mask_q;
  assign clr_wr   = wr && (bus_addr == A_CLR);
  assign clr_bits = wbits;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  begin bus_rdata[0] = en_a_q; bus_rdata[8] = en_b_q; end
      A_CFG:   bus_rdata[CFG_W-1:0]  = cfg_q;
      A_MODE:  bus_rdata[MODE_W-1:0] = mode_q;
      A_LOAD:  bus_rdata[CNT_W-1:0]  = load_q;
      A_MATCH: bus_rdata[CNT_W-1:0]  = match_q;
      A_PRESC: bus_rdata[PRE_W-1:0]  = presc_q;
      A_MASK:  for (int g = 0; g < NEV; g++) bus_rdata[EV_BITPOS[g]] = mask_q[g];
      A_RAW:   for (int g = 0; g < NEV; g++) bus_rdata[EV_BITPOS[g]] = raw[g];
      A_COUNT: bus_rdata[CNT_W-1:0]  = count;
      default: ;
    endcase
  end
endmodule

// File: rtl/pdtimer_prescale.sv
module pdtimer_prescale #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  output logic             start,
  output logic             tick
);
  logic             run_q;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  assign start = run & ~run_q;
  assign tick  = run & run_q & (pcnt_q == '0);

  always_comb begin
    pcnt_d = pcnt_q;
    if (start)            pcnt_d = presc;
    else if (tick)        pcnt_d = presc;
    else if (run & run_q) pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      run_q  <= run;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/pdtimer_core.sv
module pdtimer_core
  import pdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] load,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] count,
  output logic [NEV-1:0]   ev
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)        cnt_d = load;
    else if (tick)    cnt_d = at_zero ? load : cnt_q - 1'b1;
  end

  always_comb begin
    ev        = '0;
    ev[EV_TO] = tick & at_zero;
    ev[EV_MT] = tick & (cnt_d == match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pdtimer_status.sv
module pdtimer_status
  import pdtimer_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic           clr_wr,
  input  logic [NEV-1:0] clr_bits,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] raw,
  output logic           irq
);
  logic [NEV-1:0] raw_q, raw_d, clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;

  always_comb begin
    for (int g = 0; g < NEV; g++) raw_d[g] = (raw_q[g] & ~clr_eff[g]) | ev[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;
  assign irq = |(raw_q & mask);
endmodule

// File: rtl/pdtimer.sv
module pdtimer
  import pdtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             run, start, tick, clr_wr;
  logic [CNT_W-1:0] count, load, match;
  logic [PRE_W-1:0] presc;
  logic [NEV-1:0]   mask, raw, ev, clr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pdtimer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count), .raw(raw),
    .bus_rdata(bus_rdata), .run(run), .load(load), .match(match),
    .presc(presc), .mask(mask), .clr_wr(clr_wr), .clr_bits(clr_bits)
  );

  pdtimer_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .presc(presc),
    .start(start), .tick(tick)
  );

  pdtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .tick(tick),
    .load(load), .match(match), .count(count), .ev(ev)
  );

  pdtimer_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .mask(mask), .raw(raw), .irq(irq)
  );
endmodule

// File: rtl/pdtimer_chk.sv
module pdtimer_chk
  import pdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             start,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load,
  input logic [CNT_W-1:0] match,
  input logic [NEV-1:0]   raw,
  input logic [NEV-1:0]   ev,
  input logic             clr_wr,
  input logic [NEV-1:0]   clr_bits
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == $past(load));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0) |=> count == $past(count) - 1'b1);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0) |=> (count == $past(load)) && raw[EV_TO]);

  p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[EV_MT]) |-> count == $past(match));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[EV_TO] && !(clr_wr && clr_bits[EV_TO])) |=> raw[EV_TO]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[EV_MT] && !ev[EV_MT]) |=> !raw[EV_MT]);

  p_evwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_TO] |=> raw[EV_TO]);
endmodule

bind pdtimer pdtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .start(start), .tick(tick),
  .count(count), .load(load), .match(match), .raw(raw), .ev(ev),
  .clr_wr(clr_wr), .clr_bits(clr_bits)
);

// File: tb/pdtimer_test.sv
module pdtimer_test;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [3:0] CTRL = 4'd0, CFG = 4'd1, MODE = 4'd2, LOAD = 4'd3,
                         MATCH = 4'd4, PRESC = 4'd5, MASK = 4'd6, RAW = 4'd7,
                         CLR = 4'd8, COUNT = 4'd9;

  localparam int NV = 28;
  // {write, addr, data, expected read}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, CTRL,  32'h0000_0100, 32'h0},
    {1'b0, CTRL,  32'h0,         32'h0000_0100},
    {1'b1, CFG,   32'h0000_00FF, 32'h0},
    {1'b0, CFG,   32'h0,         32'h0000_0007},
    {1'b1, MODE,  32'h0000_1234, 32'h0},
    {1'b0, MODE,  32'h0,         32'h0000_0034},
    {1'b1, LOAD,  32'h0000_55AA, 32'h0},
    {1'b0, LOAD,  32'h0,         32'h0000_55AA},
    {1'b1, PRESC, 32'hABCD_EF01, 32'h0},
    {1'b0, PRESC, 32'h0,         32'h0000_EF01},
    {1'b1, MATCH, 32'hDEAD_BEEF, 32'h0},
    {1'b0, MATCH, 32'h0,         32'hDEAD_BEEF},
    {1'b1, MASK,  32'hFFFF_FFFF, 32'h0},
    {1'b0, MASK,  32'h0,         32'h0000_0011},
    {1'b1, CLR,   32'h0000_0000, 32'h0},
    {1'b0, CLR,   32'h0,         32'h0},
    {1'b0, RAW,   32'h0,         32'h0},
    {1'b1, CTRL,  32'h0000_0101, 32'h0},
    {1'b0, CTRL,  32'h0,         32'h0000_0101},
    {1'b0, COUNT, 32'h0,         32'h0},
    {1'b1, MASK,  32'h0,         32'h0},
    {1'b1, CTRL,  32'h0,         32'h0},
    {1'b1, CFG,   32'h4,         32'h0},
    {1'b1, MODE,  32'h22,        32'h0},
    {1'b1, MATCH, 32'h0,         32'h0},
    {1'b0, CFG,   32'h0,         32'h4},
    {1'b0, MODE,  32'h0,         32'h22},
    {1'b0, MASK,  32'h0,         32'h0}
  };

  pdtimer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (R1..R9 run) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, w;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_rd("R1 ctrl", CTRL, 0);
    chk_rd("R1 cfg", CFG, 0);
    chk_rd("R1 load", LOAD, 0);
    chk_rd("R1 raw", RAW, 0);
    chk_rd("R1 count", COUNT, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 gating: enable without the wide config / periodic mode does not count
    wr(LOAD, 32'd100);
    wr(CTRL, 32'h1);
    repeat (5) @(negedge clk);
    chk_rd("R2 no-cfg hold", COUNT, 0);
    wr(MODE, 32'h22);
    repeat (5) @(negedge clk);
    chk_rd("R2 cfg!=4 hold", COUNT, 0);
    wr(CTRL, 32'h0);

    // R9 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else            chk_rd("R9 readback", VEC[i][67:64], VEC[i][31:0]);
    end

    // R3 / R4: load 100, prescale 3
    wr(LOAD, 32'd100);
    wr(PRESC, 32'd3);
    wr(CTRL, 32'h1);
    @(negedge clk);
    chk_rd("R3 load on enable", COUNT, 100);
    repeat (3) @(negedge clk);
    chk_rd("R3 no step before P+1", COUNT, 100);
    @(negedge clk);
    chk_rd("R4 first step", COUNT, 99);
    repeat (4) @(negedge clk);
    chk_rd("R4 second step", COUNT, 98);

    // R2 stop
    wr(CTRL, 32'h0);
    rd(COUNT, v);
    repeat (6) @(negedge clk);
    rd(COUNT, w);
    chk("R2 stop holds", w, v);

    // R5 / R6 / R7: load 2, prescale 0, match 1, mask 0
    wr(LOAD, 32'd2);
    wr(PRESC, 32'd0);
    wr(MATCH, 32'd1);
    wr(MASK, 32'h0);
    wr(CLR, 32'h11);
    wr(CTRL, 32'h1);
    @(negedge clk);
    chk_rd("R3 reload start", COUNT, 2);
    chk_rd("R6 raw before match", RAW, 0);
    @(negedge clk);
    chk_rd("R4 step", COUNT, 1);
    chk_rd("R6 match raw", RAW, 32'h10);
    chk("R7 masked irq low", {31'b0, irq}, 0);
    @(negedge clk);
    chk_rd("R4 step to zero", COUNT, 0);
    chk_rd("R7 sticky match", RAW, 32'h10);
    @(negedge clk);
    chk_rd("R5 reload", COUNT, 2);
    chk_rd("R5 timeout raw", RAW, 32'h11);
    wr(CTRL, 32'h0);

    // R8 selective clear, R7 mask to irq
    wr(CLR, 32'h10);
    chk_rd("R8 partial clear", RAW, 32'h01);
    chk("R7 irq mask0", {31'b0, irq}, 0);
    wr(MASK, 32'h01);
    chk("R7 irq timeout unmasked", {31'b0, irq}, 1);
    wr(MASK, 32'h10);
    chk("R7 irq other bit masked", {31'b0, irq}, 0);
    wr(CLR, 32'h01);
    chk_rd("R8 full clear", RAW, 0);
    wr(MASK, 32'h0);

    // R8 collision: interval 0 gives a timeout every clock
    wr(LOAD, 32'd0);
    wr(MATCH, 32'd5);
    wr(CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(MATCH, 32'd0);
    wr(MATCH, 32'd5);
    wr(CLR, 32'h11);
    chk_rd("R8 event wins over clear", RAW, 32'h01);
    wr(CTRL, 32'h0);
    wr(CLR, 32'h11);
    chk_rd("R8 cleared after stop", RAW, 0);

    // R5 full-width interval
    wr(LOAD, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    @(negedge clk);
    chk_rd("R5 full load", COUNT, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_rd("R5 full first step", COUNT, 32'hFFFF_FFFE);
    wr(CTRL, 32'h0);

    finish_run();
  end
endmodule